// File: doc/BRIEF.md
# Operand-Snooping Issue Queue Bank

This block is a small bank of waiting slots that sits in front of one class of functional unit in an out-of-order core. The issue stage writes an instruction into a free slot. Each source operand arrives either as a value or as the tag of the instruction that will produce it. Every slot compares its outstanding tags with the shared result bus in every cycle. When a tag matches, the slot copies the value from the bus. No producer keeps a list of its consumers: one broadcast updates every slot that waits on that tag.

Once a slot has both operands, it competes for dispatch into a pipelined fixed-latency unit. The oldest ready slot by program-order sequence number wins, and one slot is dispatched per cycle. The finished result is stored back in its slot. The slot then presents a request to an external bus arbiter, together with its destination tag and sequence number. The slot stays occupied until that arbiter grants the request, and it is released in the grant cycle. The register file and the arbitration policy are outside the block.

Top module: `resv_station_bank`

## Requirements
- R1: After a synchronous reset every slot is empty: `iss_ready` is 1 and `req_valid` is 0.
- R2: An issue is accepted only in a cycle where `iss_valid` and `iss_ready` are both 1. `iss_ready` is 0 while all NUM_ENT slots are occupied. An issue attempted while `iss_ready` is 0 leaves no trace and never produces a result.
- R3: Tag value 0 means "no producer". A source whose issue tag is 0 takes the issue value. A source with a nonzero tag ignores the issue value and blocks dispatch of its slot until that tag is captured.
- R4: In a cycle with `bus_valid` = 1, every occupied slot whose first and/or second source tag equals `bus_tag` loads `bus_data` into that source and clears its tag. Any number of slots, and both sources of one slot, may capture in the same cycle.
- R5: If an issuing source names the tag that is on the bus in the same cycle, the new slot takes `bus_data` for that source and does not wait.
- R6: A slot whose last operand is captured (or issued ready) at the end of cycle N is dispatched in cycle N+1 when it is the oldest ready slot. A dispatch in cycle S makes `req_valid` visible for that slot in cycle S+LAT and not earlier.
- R7: When several slots are ready, the one with the oldest sequence number is dispatched first, at most one per cycle.
- R8: Among finished slots the oldest presents `req_tag`, `req_data` and `req_seq`. The request stays valid until `grant` is 1, and the slot is freed at the end of the grant cycle.
- R9: The operation codes are 0 = add, 1 = subtract (first minus second), 2 = bitwise and, 3 = bitwise xor, all modulo 2^DATA_W. `req_seq` equals the sequence number given at issue, and `req_tag` equals the destination tag given at issue.
- R10: Sequence numbers compare by wrap-around: a is older than b when (a − b) mod 2^SEQ_W has its top bit set, so 62 is older than 1 for SEQ_W = 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | 2 | Operation code |
| iss_vj | input | DATA_W | First source value |
| iss_qj | input | TAG_W | First source producer tag, 0 = ready |
| iss_vk | input | DATA_W | Second source value |
| iss_qk | input | TAG_W | Second source producer tag, 0 = ready |
| iss_dst | input | TAG_W | Destination tag (nonzero) |
| iss_seq | input | SEQ_W | Program-order sequence number |
| iss_ready | output | 1 | A free slot exists |
| bus_valid | input | 1 | Result bus carries a broadcast |
| bus_tag | input | TAG_W | Broadcast producer tag |
| bus_data | input | DATA_W | Broadcast value |
| req_valid | output | 1 | A finished result awaits the bus |
| req_tag | output | TAG_W | Destination tag of the requesting slot |
| req_data | output | DATA_W | Result of the requesting slot |
| req_seq | output | SEQ_W | Sequence number of the requesting slot |
| grant | input | 1 | Arbiter grants the request this cycle |

## Verification
Directed cases fill the bank with four slots that all wait on one external tag, one of them on that tag for both sources. A single broadcast must release them all, and they must come back in age order rather than slot order, which separates per-slot capture and oldest-first selection from index-ordered schemes. Further directed cases cover an issue that names the tag on the bus in the same cycle, a sequence-number wrap, an issue attempted while the bank is full, and the exact cycle in which the request appears. The random phase mixes ready values, external tags and tags of the bank's own pending results, and it withholds grants at random. This exposes lost captures, stale operands and results released before they are granted.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } rsb_op_e;

endpackage

// File: rtl/rsb_oldest_pick.sv
module rsb_oldest_pick #(
  parameter int N     = 4,
  parameter int SEQ_W = 6,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]            cand,
  input  logic [N-1:0][SEQ_W-1:0] seqs,
  output logic                    found,
  output logic [IDX_W-1:0]        idx,
  output logic [N-1:0]            onehot
);

  function automatic logic is_older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] diff;
    diff = a - b;
    return diff[SEQ_W-1];
  endfunction

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (cand[i] && (!found || is_older(seqs[i], seqs[idx]))) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
    onehot = found ? (N'(1) << idx) : '0;
  end

endmodule

// File: rtl/rsb_fu_pipe.sv
module rsb_fu_pipe
  import rsb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2,
  parameter int LAT    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  rsb_op_e           in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [IDX_W-1:0]  in_idx,
  output logic              out_valid,
  output logic [IDX_W-1:0]  out_idx,
  output logic [DATA_W-1:0] out_data
);

  logic [DATA_W-1:0] alu_res;

  always_comb begin
    unique case (in_op)
      OP_ADD:  alu_res = in_a + in_b;
      OP_SUB:  alu_res = in_a - in_b;
      OP_AND:  alu_res = in_a & in_b;
      default: alu_res = in_a ^ in_b;
    endcase
  end

  generate
    if (LAT <= 1) begin : g_direct
      assign out_valid = in_valid;
      assign out_idx   = in_idx;
      assign out_data  = alu_res;
    end else begin : g_stages
      localparam int PD = LAT - 1;
      logic [PD-1:0]     st_v;
      logic [IDX_W-1:0]  st_i [PD];
      logic [DATA_W-1:0] st_d [PD];

      always_ff @(posedge clk) begin
        if (rst) begin
          st_v <= '0;
        end else begin
          st_v <= {st_v[PD-1:0], in_valid} >> 0;
        end
      end

      always_ff @(posedge clk) begin
        st_i[0] <= in_idx;
        st_d[0] <= alu_res;
        for (int k = 1; k < PD; k++) begin
          st_i[k] <= st_i[k-1];
          st_d[k] <= st_d[k-1];
        end
      end

      assign out_valid = st_v[PD-1];
      assign out_idx   = st_i[PD-1];
      assign out_data  = st_d[PD-1];
    end
  endgenerate

endmodule

// File: rtl/resv_station_bank.sv
module resv_station_bank
  import rsb_pkg::*;
#(
  parameter int NUM_ENT = 4,
  parameter int DATA_W  = 16,
  parameter int TAG_W   = 4,
  parameter int SEQ_W   = 6,
  parameter int LAT     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [1:0]        iss_op,
  input  logic [DATA_W-1:0] iss_vj,
  input  logic [TAG_W-1:0]  iss_qj,
  input  logic [DATA_W-1:0] iss_vk,
  input  logic [TAG_W-1:0]  iss_qk,
  input  logic [TAG_W-1:0]  iss_dst,
  input  logic [SEQ_W-1:0]  iss_seq,
  output logic              iss_ready,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  output logic              req_valid,
  output logic [TAG_W-1:0]  req_tag,
  output logic [DATA_W-1:0] req_data,
  output logic [SEQ_W-1:0]  req_seq,
  input  logic              grant
);

  localparam int IDX_W = (NUM_ENT > 1) ? $clog2(NUM_ENT) : 1;

  // slot control
  logic [NUM_ENT-1:0] ent_busy, ent_disp, ent_done;
  // slot payload; the first-source field is reused as the result holder
  rsb_op_e            ent_op  [NUM_ENT];
  logic [DATA_W-1:0]  ent_vj  [NUM_ENT];
  logic [DATA_W-1:0]  ent_vk  [NUM_ENT];
  logic [TAG_W-1:0]   ent_qj  [NUM_ENT];
  logic [TAG_W-1:0]   ent_qk  [NUM_ENT];
  logic [TAG_W-1:0]   ent_dst [NUM_ENT];
  logic [NUM_ENT-1:0][SEQ_W-1:0] ent_seq;

  logic [NUM_ENT-1:0] free_vec, alloc_oh, ent_wait, rdy_vec, fin_vec;
  logic [NUM_ENT-1:0] disp_oh, req_oh;
  logic               disp_found, req_found, alloc_found;
  logic [IDX_W-1:0]   disp_idx, req_idx;
  logic               iss_fire, grant_fire, byp_j, byp_k;
  logic               wb_valid;
  logic [IDX_W-1:0]   wb_idx;
  logic [DATA_W-1:0]  wb_data;

  assign free_vec = ~ent_busy;
  assign iss_ready = |free_vec;
  assign iss_fire  = iss_valid && iss_ready;

  // lowest free slot takes the next issue
  always_comb begin
    alloc_oh    = '0;
    alloc_found = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (free_vec[i] && !alloc_found) begin
        alloc_oh[i] = 1'b1;
        alloc_found = 1'b1;
      end
    end
  end

  // same-cycle forwarding of the bus into an issuing slot
  assign byp_j = bus_valid && (iss_qj != '0) && (iss_qj == bus_tag);
  assign byp_k = bus_valid && (iss_qk != '0) && (iss_qk == bus_tag);

  always_comb begin
    for (int i = 0; i < NUM_ENT; i++) begin
      ent_wait[i] = (ent_qj[i] != '0) || (ent_qk[i] != '0);
    end
  end

  assign rdy_vec = ent_busy & ~ent_disp & ~ent_wait;
  assign fin_vec = ent_busy & ent_done;

  rsb_oldest_pick #(.N(NUM_ENT), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) i_disp_pick (
    .cand   (rdy_vec),
    .seqs   (ent_seq),
    .found  (disp_found),
    .idx    (disp_idx),
    .onehot (disp_oh)
  );

  rsb_oldest_pick #(.N(NUM_ENT), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) i_req_pick (
    .cand   (fin_vec),
    .seqs   (ent_seq),
    .found  (req_found),
    .idx    (req_idx),
    .onehot (req_oh)
  );

  rsb_fu_pipe #(.DATA_W(DATA_W), .IDX_W(IDX_W), .LAT(LAT)) i_fu (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (disp_found),
    .in_op     (ent_op[disp_idx]),
    .in_a      (ent_vj[disp_idx]),
    .in_b      (ent_vk[disp_idx]),
    .in_idx    (disp_idx),
    .out_valid (wb_valid),
    .out_idx   (wb_idx),
    .out_data  (wb_data)
  );

  assign grant_fire = grant && req_found;

  // control state
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_ENT; i++) begin
      if (rst) begin
        ent_busy[i] <= 1'b0;
        ent_disp[i] <= 1'b0;
        ent_done[i] <= 1'b0;
      end else if (grant_fire && req_oh[i]) begin
        ent_busy[i] <= 1'b0;
        ent_disp[i] <= 1'b0;
        ent_done[i] <= 1'b0;
      end else if (iss_fire && alloc_oh[i]) begin
        ent_busy[i] <= 1'b1;
        ent_disp[i] <= 1'b0;
        ent_done[i] <= 1'b0;
      end else begin
        if (disp_oh[i]) ent_disp[i] <= 1'b1;
        if (wb_valid && (wb_idx == IDX_W'(i))) ent_done[i] <= 1'b1;
      end
    end
  end

  // payload: load at issue, snoop while waiting, take the result when done
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_ENT; i++) begin
      if (iss_fire && alloc_oh[i]) begin
        ent_op[i]  <= rsb_op_e'(iss_op);
        ent_dst[i] <= iss_dst;
        ent_seq[i] <= iss_seq;
        ent_vj[i]  <= byp_j ? bus_data : iss_vj;
        ent_qj[i]  <= byp_j ? '0 : iss_qj;
        ent_vk[i]  <= byp_k ? bus_data : iss_vk;
        ent_qk[i]  <= byp_k ? '0 : iss_qk;
      end else if (ent_busy[i]) begin
        if (bus_valid && (ent_qj[i] != '0) && (ent_qj[i] == bus_tag)) begin
          ent_vj[i] <= bus_data;
          ent_qj[i] <= '0;
        end
        if (bus_valid && (ent_qk[i] != '0) && (ent_qk[i] == bus_tag)) begin
          ent_vk[i] <= bus_data;
          ent_qk[i] <= '0;
        end
        if (wb_valid && (wb_idx == IDX_W'(i))) begin
          ent_vj[i] <= wb_data;
        end
      end
    end
  end

  assign req_valid = req_found;
  assign req_tag   = ent_dst[req_idx];
  assign req_data  = ent_vj[req_idx];
  assign req_seq   = ent_seq[req_idx];

endmodule

// File: rtl/rsb_checker.sv
module rsb_checker #(
  parameter int NUM_ENT = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               iss_ready,
  input logic               req_valid,
  input logic               grant,
  input logic [NUM_ENT-1:0] disp_vec,
  input logic [NUM_ENT-1:0] wait_vec
);

  property p_reset_empty;
    @(posedge clk) disable iff (rst) $past(rst) |-> (iss_ready && !req_valid);
  endproperty
  assert_reset_empty_R1: assert property (p_reset_empty);

  property p_grant_frees;
    @(posedge clk) disable iff (rst) (req_valid && grant) |=> iss_ready;
  endproperty
  assert_grant_frees_R2: assert property (p_grant_frees);

  property p_waiting_not_sent;
    @(posedge clk) disable iff (rst) ((disp_vec & wait_vec) == '0);
  endproperty
  assert_waiting_not_sent_R3: assert property (p_waiting_not_sent);

  property p_single_dispatch;
    @(posedge clk) disable iff (rst) $onehot0(disp_vec);
  endproperty
  assert_single_dispatch_R7: assert property (p_single_dispatch);

  property p_request_held;
    @(posedge clk) disable iff (rst) (req_valid && !grant) |=> req_valid;
  endproperty
  assert_request_held_R8: assert property (p_request_held);

endmodule

bind resv_station_bank rsb_checker #(.NUM_ENT(NUM_ENT)) i_rsb_checker (
  .clk       (clk),
  .rst       (rst),
  .iss_ready (iss_ready),
  .req_valid (req_valid),
  .grant     (grant),
  .disp_vec  (disp_oh),
  .wait_vec  (ent_wait)
);

// File: tb/test_resv_station_bank.sv
module test_resv_station_bank;

  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        iss_valid = 1'b0;
  logic [1:0]  iss_op = '0;
  logic [15:0] iss_vj = '0, iss_vk = '0;
  logic [3:0]  iss_qj = '0, iss_qk = '0, iss_dst = '0;
  logic [5:0]  iss_seq = '0;
  logic        iss_ready;
  logic        bus_valid = 1'b0;
  logic [3:0]  bus_tag = '0;
  logic [15:0] bus_data = '0;
  logic        req_valid;
  logic [3:0]  req_tag;
  logic [15:0] req_data;
  logic [5:0]  req_seq;
  logic        grant = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  resv_station_bank #(.NUM_ENT(4), .DATA_W(16), .TAG_W(4), .SEQ_W(6), .LAT(LAT)) i_resv_station_bank (
    .clk(clk), .rst(rst),
    .iss_valid(iss_valid), .iss_op(iss_op), .iss_vj(iss_vj), .iss_qj(iss_qj),
    .iss_vk(iss_vk), .iss_qk(iss_qk), .iss_dst(iss_dst), .iss_seq(iss_seq),
    .iss_ready(iss_ready),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
    .req_valid(req_valid), .req_tag(req_tag), .req_data(req_data), .req_seq(req_seq),
    .grant(grant)
  );

  function automatic logic [15:0] exp_alu(input logic [1:0] op, input logic [15:0] a, input logic [15:0] b);
    case (op)
      2'd0:    return a + b;
      2'd1:    return a - b;
      2'd2:    return a & b;
      default: return a ^ b;
    endcase
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    iss_valid = 1'b0; bus_valid = 1'b0; grant = 1'b0;
  endtask

  task automatic issue(input logic [1:0] op, input logic [15:0] vj, input logic [3:0] qj,
                       input logic [15:0] vk, input logic [3:0] qk,
                       input logic [3:0] dst, input logic [5:0] sq);
    iss_valid = 1'b1; iss_op = op; iss_vj = vj; iss_qj = qj;
    iss_vk = vk; iss_qk = qk; iss_dst = dst; iss_seq = sq;
  endtask

  task automatic bcast(input logic [3:0] t, input logic [15:0] d);
    bus_valid = 1'b1; bus_tag = t; bus_data = d;
  endtask

  // grant the current request, forwarding it onto the bus, after checking it
  task automatic take(input string rq, input logic [5:0] esq, input logic [15:0] edat, input logic [3:0] etag);
    chk(req_valid && req_seq == esq && req_tag == etag, rq, req_seq, esq);
    chk(req_data == edat, rq, req_data, edat);
    grant = 1'b1; bcast(req_tag, req_data);
    tick();
    idle();
  endtask

  // bench model for the random phase, indexed by destination tag 1..7
  bit          m_busy [8];
  logic [1:0]  m_op   [8];
  logic [15:0] m_vj   [8], m_vk [8];
  logic [3:0]  m_qj   [8], m_qk [8];
  logic [5:0]  m_seq  [8];

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [5:0] seq_ctr;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) m_busy[i] = 1'b0;

    @(negedge clk);
    tick(); tick();
    rst = 1'b0;
    tick();

    // R1: empty after reset
    chk(iss_ready == 1'b1, "R1 ready after reset", iss_ready, 1);
    chk(req_valid == 1'b0, "R1 no request after reset", req_valid, 0);

    // R6/R9: ready operands, exact request cycle
    issue(2'd0, 16'd100, 4'd0, 16'd23, 4'd0, 4'd1, 6'd0);
    tick(); idle();
    for (int c = 1; c < LAT; c++) tick();
    chk(req_valid == 1'b0, "R6 no request before S+LAT", req_valid, 0);
    tick();
    chk(req_valid == 1'b1, "R6 request at S+LAT", req_valid, 1);
    chk(req_data == 16'd123 && req_tag == 4'd1, "R9 add result", req_data, 123);
    tick(); tick();
    chk(req_valid && req_tag == 4'd1, "R8 request held without grant", req_tag, 1);
    grant = 1'b1; bcast(req_tag, req_data);
    tick(); idle();
    chk(req_valid == 1'b0, "R8 slot released after grant", req_valid, 0);

    // R2/R4/R7/R9: fill the bank, all waiting on tag 9
    issue(2'd0, 16'h1111, 4'd9, 16'h0005, 4'd0, 4'd2, 6'd10); tick();
    issue(2'd1, 16'h2222, 4'd9, 16'h0003, 4'd0, 4'd3, 6'd9);  tick();
    issue(2'd2, 16'h3333, 4'd9, 16'h1234, 4'd9, 4'd4, 6'd8);  tick();
    issue(2'd3, 16'h4444, 4'd9, 16'h0F0F, 4'd0, 4'd5, 6'd7);  tick();
    idle();
    chk(iss_ready == 1'b0, "R2 full bank stalls issue", iss_ready, 0);
    issue(2'd0, 16'd1, 4'd0, 16'd1, 4'd0, 4'd6, 6'd11); tick(); idle();
    tick(); tick();
    chk(req_valid == 1'b0, "R3 waiting slots not dispatched", req_valid, 0);
    bcast(4'd9, 16'h0040); tick(); idle();
    repeat (8) tick();
    take("R7 oldest first xor", 6'd7,  16'h0F4F, 4'd5);
    take("R4 both sources and", 6'd8,  16'h0040, 4'd4);
    take("R9 sub result",       6'd9,  16'h003D, 4'd3);
    take("R4 add result",       6'd10, 16'h0045, 4'd2);
    chk(req_valid == 1'b0, "R2 issue while full left no trace", req_valid, 0);
    chk(iss_ready == 1'b1, "R8 all slots free", iss_ready, 1);

    // R5: issue names the tag on the bus in the same cycle
    issue(2'd0, 16'h7777, 4'd10, 16'h0001, 4'd0, 4'd6, 6'd12);
    bcast(4'd10, 16'h0200);
    tick(); idle();
    repeat (LAT + 2) tick();
    take("R5 same-cycle forward", 6'd12, 16'h0201, 4'd6);

    // R10: wrap-around age
    issue(2'd1, 16'h0, 4'd11, 16'h0001, 4'd0, 4'd7, 6'd1);  tick();
    issue(2'd0, 16'h0, 4'd11, 16'h0001, 4'd0, 4'd1, 6'd62); tick();
    idle();
    bcast(4'd11, 16'd50); tick(); idle();
    repeat (LAT + 3) tick();
    take("R10 seq 62 older than 1", 6'd62, 16'd51, 4'd1);
    take("R10 younger after wrap",  6'd1,  16'd49, 4'd7);

    // R6: capture cycle to request cycle
    issue(2'd3, 16'h0, 4'd12, 16'h00FF, 4'd0, 4'd2, 6'd13); tick(); idle();
    tick(); tick();
    chk(req_valid == 1'b0, "R3 waits for tag 12", req_valid, 0);
    bcast(4'd12, 16'h0F00); tick(); idle();
    for (int c = 1; c < LAT; c++) tick();
    chk(req_valid == 1'b0, "R6 no request before capture+1+LAT", req_valid, 0);
    tick();
    chk(req_valid == 1'b1, "R6 request at capture+1+LAT", req_valid, 1);
    take("R4 captured xor", 6'd13, 16'h0FFF, 4'd2);

    // random phase
    seq_ctr = 6'd20;
    for (int cyc = 0; cyc < 3000 + 400; cyc++) begin
      bit          g, bv, iv, found;
      logic [3:0]  btag, dst, gtag;
      logic [15:0] bdat;
      bit          draining;
      draining = (cyc >= 3000);
      g = 1'b0; bv = 1'b0; iv = 1'b0; found = 1'b0;
      btag = '0; bdat = '0; dst = '0; gtag = '0;
      if (req_valid && (draining || ($urandom % 4) != 0)) begin
        logic [15:0] e;
        g = 1'b1; bv = 1'b1; btag = req_tag; bdat = req_data; gtag = req_tag;
        e = exp_alu(m_op[req_tag[2:0]], m_vj[req_tag[2:0]], m_vk[req_tag[2:0]]);
        chk(req_tag != 0 && req_tag < 8 && m_busy[req_tag[2:0]] &&
            m_qj[req_tag[2:0]] == 0 && m_qk[req_tag[2:0]] == 0 &&
            req_seq == m_seq[req_tag[2:0]] && req_data == e,
            "R9 random result", req_data, e);
      end else if (($urandom % 2) != 0) begin
        bv = 1'b1; btag = 4'(8 + ($urandom % 8)); bdat = 16'($urandom);
      end
      if (!draining) begin
        int st;
        st = $urandom % 7;
        for (int k = 0; k < 7; k++) begin
          int t;
          t = 1 + (st + k) % 7;
          if (!found && !m_busy[t]) begin found = 1'b1; dst = 4'(t); end
        end
        iv = found && (($urandom % 3) != 0);
      end
      if (iv) begin
        logic [15:0] v [2];
        logic [3:0]  q [2];
        for (int s = 0; s < 2; s++) begin
          int r;
          r = $urandom % 4;
          v[s] = 16'($urandom);
          q[s] = '0;
          if (r == 2) q[s] = 4'(8 + ($urandom % 8));
          if (r == 3) begin
            int st2;
            st2 = $urandom % 7;
            for (int k = 0; k < 7; k++) begin
              int t;
              t = 1 + (st2 + k) % 7;
              if (q[s] == 0 && m_busy[t]) q[s] = 4'(t);
            end
          end
        end
        issue(2'($urandom % 4), v[0], q[0], v[1], q[1], dst, seq_ctr);
        if (iss_ready) begin
          m_busy[dst[2:0]] = 1'b1;
          m_op[dst[2:0]]   = iss_op;
          m_vj[dst[2:0]]   = v[0]; m_qj[dst[2:0]] = q[0];
          m_vk[dst[2:0]]   = v[1]; m_qk[dst[2:0]] = q[1];
          m_seq[dst[2:0]]  = seq_ctr;
          seq_ctr = seq_ctr + 6'd1;
        end
      end else begin
        iss_valid = 1'b0;
      end
      if (bv) begin
        bcast(btag, bdat);
        for (int t = 1; t < 8; t++) begin
          if (m_busy[t] && m_qj[t] == btag) begin m_vj[t] = bdat; m_qj[t] = '0; end
          if (m_busy[t] && m_qk[t] == btag) begin m_vk[t] = bdat; m_qk[t] = '0; end
        end
      end else begin
        bus_valid = 1'b0;
      end
      grant = g;
      if (g) m_busy[gtag[2:0]] = 1'b0;
      tick();
    end
    idle();
    begin
      int left;
      left = 0;
      for (int t = 1; t < 8; t++) if (m_busy[t]) left++;
      chk(left == 0 && req_valid == 1'b0 && iss_ready == 1'b1, "R8 every issued result returned", left, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule